// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block chooses which of two oscillators drives the core clock: an internal oscillator that is always available, or an external crystal oscillator that needs time to settle. After reset, after wake from sleep, and whenever software asks for the external source again, the core runs from the internal clock while a start-up timer in the external clock domain counts external cycles. Only when that count is complete does the switch hand the core over to the external clock. The output is first parked low and then picks up the external clock on one of its falling edges, so the core never sees a shortened phase.

A failure monitor samples the external clock with the internal clock. When monitoring is enabled and the external source is in use or warming up, a run of `fail_limit` internal cycles with no external edge raises `clk_fail`. The switch then returns to the internal clock, even if the external clock has stopped high. A separate pair of flags reports whether the internal oscillator has been enabled long enough to be ready and to be stable. The oscillators are modelled as free-running clock inputs. All control inputs are synchronous to `clk_int`.

Top module: `clk_src_switch`

## Requirements
- R1: After a start-up is launched, `ost_done` rises only after the external clock has given at least OST_CYC (default 1024) rising edges, and no more than 10 edges later than that. The flag passes through two `clk_int` flops before it is visible.
- R2: `on_ext` (external clock driving `clk_out`, synchronized into `clk_int`) stays 0 until `ost_done` has been seen high. Once it is 1, `clk_out` has the period of `clk_ext`.
- R3: No high or low phase of `clk_out` is shorter than the shorter half-period of the two source clocks. On a change of source the output is held low, and the new clock's enable opens only while that clock is low.
- R4: `ost_done` returns to 0, and a full OST_CYC count is made again, on each of three paths: release of reset, wake from sleep, and a new external request made while running from the internal clock.
- R5: While `sleep_req` is 1, `clk_out` has no edges and `on_ext` is 0.
- R6: Clearing `sel_ext_req` returns the output to the internal clock: `on_ext` goes to 0 and `clk_out` has the period of `clk_int`.
- R7: `int_ready` is 1 once `int_en` has been sampled high on RDY_CYC (default 4) consecutive `clk_int` edges. `int_stable` is 1 once this has held for STB_CYC (default 16) edges. Both flags are 0 on the cycle after `int_en` is sampled low.
- R8: With `fscm_en` set and the external clock in use, `fail_limit` `clk_int` cycles with no external edge raise `clk_fail` within `fail_limit`+10 cycles. The output then returns to the internal clock. `clk_fail` stays set until `sel_ext_req` is cleared, or until sleep is entered.
- R9: If the external oscillator does not start during warm-up, `clk_fail` rises within `fail_limit`+10 cycles of the request, and `on_ext` stays 0.
- R10: With `fscm_en` clear, `clk_fail` never rises. A dead external clock then leaves the request pending on the internal clock, and the switch completes once the external clock starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator clock; clocks all control logic |
| clk_ext | input | 1 | External crystal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| int_en | input | 1 | Internal oscillator enable, drives the ready/stable flags |
| sleep_req | input | 1 | 1 = sleep (output clock stopped), 0 = run |
| sel_ext_req | input | 1 | Software request: 1 = run from external clock |
| fscm_en | input | 1 | 1 = external clock failure monitoring enabled |
| fail_limit | input | FAIL_W | Internal cycles without an external edge that count as failure (must be at least 1) |
| clk_out | output | 1 | Switched core clock |
| on_ext | output | 1 | 1 = external clock is driving clk_out |
| ost_done | output | 1 | Start-up timer has completed its count |
| clk_fail | output | 1 | External clock failure detected |
| int_ready | output | 1 | Internal oscillator ready |
| int_stable | output | 1 | Internal oscillator stable |

## Verification
The bench goes after the three restart paths of the start-up timer. A timer that kept its count across sleep or across a return to the internal clock would raise `ost_done` a few edges after the new request, where about 1024 are expected. A monitor times every phase of `clk_out` through each handover and during sleep: a mux that switched enables on the wrong edge would show a sliver of high or low time. The bench also stops the external clock while it is in use and before it ever starts. A switch whose external enable could only close on an external edge would hang on the dead clock, and a monitor that ignored `fscm_en` would raise `clk_fail` in the disabled phase.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
  typedef enum logic [2:0] {
    ST_INT   = 3'd0,
    ST_WARM  = 3'd1,
    ST_EXT   = 3'd2,
    ST_FAIL  = 3'd3,
    ST_SLEEP = 3'd4
  } csw_state_t;
endpackage

// File: rtl/csw_ost.sv
`timescale 1ns/1ps
// Start-up timer in the external clock domain.
module csw_ost #(
  parameter int OST_CYC = 1024
) (
  input  logic clk_ext,
  input  logic arst_n,
  input  logic want,
  output logic done
);
  localparam int OCW = $clog2(OST_CYC + 1);

  logic [1:0]     want_s;
  logic [OCW-1:0] cnt;

  always_ff @(posedge clk_ext or negedge arst_n) begin
    if (!arst_n) want_s <= '0;
    else         want_s <= {want_s[0], want};
  end

  // Counting restarts from zero whenever the request is withdrawn.
  always_ff @(posedge clk_ext or negedge arst_n) begin
    if (!arst_n)                   cnt <= '0;
    else if (!want_s[1])           cnt <= '0;
    else if (cnt != OCW'(OST_CYC)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == OCW'(OST_CYC));
endmodule

// File: rtl/csw_fail_det.sv
`timescale 1ns/1ps
// Watches the external clock from the internal clock domain.
module csw_fail_det #(
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ext,
  input  logic              arm,
  input  logic [FAIL_W-1:0] limit,
  output logic              stale
);
  logic [2:0]        smp;
  logic [FAIL_W-1:0] gap;
  logic              edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[1:0], clk_ext};
  end

  assign edge_seen = smp[2] ^ smp[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap <= '0;
    else if (!arm)      gap <= '0;
    else if (edge_seen) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  assign stale = arm && (gap >= limit);
endmodule

// File: rtl/csw_glitch_mux.sv
`timescale 1ns/1ps
// Two-stage enable per clock domain; each enable changes on its own falling edge.
module csw_glitch_mux (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic ext_arst_n,
  input  logic req_int,
  input  logic req_ext,
  output logic clk_out,
  output logic en_int,
  output logic en_ext
);
  logic i_meta, i_en, e_meta, e_en;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) i_meta <= 1'b0;
    else        i_meta <= req_int & ~(e_meta | e_en);
  end

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) i_en <= 1'b0;
    else        i_en <= i_meta;
  end

  always_ff @(posedge clk_ext or negedge ext_arst_n) begin
    if (!ext_arst_n) e_meta <= 1'b0;
    else             e_meta <= req_ext & ~(i_meta | i_en);
  end

  always_ff @(negedge clk_ext or negedge ext_arst_n) begin
    if (!ext_arst_n) e_en <= 1'b0;
    else             e_en <= e_meta;
  end

  assign clk_out = (clk_int & i_en) | (clk_ext & e_en);
  assign en_int  = i_en;
  assign en_ext  = e_en;

  // R3: the two enables never overlap
  a_r3_enables_exclusive: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(i_en && e_en));
endmodule

// File: rtl/csw_ctrl.sv
`timescale 1ns/1ps
// Source selection sequencer and internal oscillator status flags.
module csw_ctrl
  import csw_pkg::*;
#(
  parameter int RDY_CYC = 4,
  parameter int STB_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic sel_ext_req,
  input  logic fscm_en,
  input  logic done_s,
  input  logic stale,
  input  logic int_en,
  output logic ext_want,
  output logic use_ext,
  output logic sleeping,
  output logic failed,
  output logic int_ready,
  output logic int_stable
);
  localparam int SCW = $clog2(STB_CYC + 1);

  csw_state_t     state, nxt;
  logic [SCW-1:0] fcnt;

  always_comb begin
    nxt = state;
    if (sleep_req && state != ST_SLEEP) begin
      nxt = ST_SLEEP;
    end else begin
      unique case (state)
        ST_SLEEP: if (!sleep_req) nxt = ST_INT;
        ST_INT:   if (sel_ext_req && !done_s) nxt = ST_WARM;
        ST_WARM: begin
          if (!sel_ext_req)         nxt = ST_INT;
          else if (fscm_en && stale) nxt = ST_FAIL;
          else if (done_s)           nxt = ST_EXT;
        end
        ST_EXT: begin
          if (!sel_ext_req)         nxt = ST_INT;
          else if (fscm_en && stale) nxt = ST_FAIL;
        end
        ST_FAIL:  if (!sel_ext_req) nxt = ST_INT;
        default:  nxt = ST_INT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_INT;
    else        state <= nxt;
  end

  assign ext_want = (state == ST_WARM) || (state == ST_EXT);
  assign use_ext  = (state == ST_EXT);
  assign sleeping = (state == ST_SLEEP);
  assign failed   = (state == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     fcnt <= '0;
    else if (!int_en)               fcnt <= '0;
    else if (fcnt != SCW'(STB_CYC)) fcnt <= fcnt + 1'b1;
  end

  assign int_ready  = (fcnt >= SCW'(RDY_CYC));
  assign int_stable = (fcnt == SCW'(STB_CYC));

  // R2: external source used only with a completed start-up count
  a_r2_ext_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXT) |-> done_s);
  // R10: failure is only declared while monitoring is on
  a_r10_fail_needs_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed) |-> $past(fscm_en));
  // R7: disabling the oscillator clears both flags
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> (!int_ready && !int_stable));
  // R7: stable implies ready
  a_r7_stable_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    int_stable |-> int_ready);
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch #(
  parameter int OST_CYC = 1024,
  parameter int RDY_CYC = 4,
  parameter int STB_CYC = 16,
  parameter int FAIL_W  = 8
) (
  input  logic              clk_int,
  input  logic              clk_ext,
  input  logic              rst_n,
  input  logic              int_en,
  input  logic              sleep_req,
  input  logic              sel_ext_req,
  input  logic              fscm_en,
  input  logic [FAIL_W-1:0] fail_limit,
  output logic              clk_out,
  output logic              on_ext,
  output logic              ost_done,
  output logic              clk_fail,
  output logic              int_ready,
  output logic              int_stable
);
  logic       ext_want, use_ext, sleeping, failed, stale, arm;
  logic       done_e, en_i, en_e, ext_arst_n;
  logic [1:0] done_sync, on_sync;

  // Failure holds the external domain in reset, so a dead clock cannot hang it.
  assign ext_arst_n = rst_n & ~failed;
  assign arm        = fscm_en & ext_want;

  csw_ctrl #(.RDY_CYC(RDY_CYC), .STB_CYC(STB_CYC)) u_ctrl (
    .clk        (clk_int),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .sel_ext_req(sel_ext_req),
    .fscm_en    (fscm_en),
    .done_s     (done_sync[1]),
    .stale      (stale),
    .int_en     (int_en),
    .ext_want   (ext_want),
    .use_ext    (use_ext),
    .sleeping   (sleeping),
    .failed     (failed),
    .int_ready  (int_ready),
    .int_stable (int_stable)
  );

  csw_ost #(.OST_CYC(OST_CYC)) u_ost (
    .clk_ext(clk_ext),
    .arst_n (ext_arst_n),
    .want   (ext_want),
    .done   (done_e)
  );

  csw_fail_det #(.FAIL_W(FAIL_W)) u_fail (
    .clk    (clk_int),
    .rst_n  (rst_n),
    .clk_ext(clk_ext),
    .arm    (arm),
    .limit  (fail_limit),
    .stale  (stale)
  );

  csw_glitch_mux u_mux (
    .clk_int   (clk_int),
    .clk_ext   (clk_ext),
    .rst_n     (rst_n),
    .ext_arst_n(ext_arst_n),
    .req_int   (~sleeping & ~use_ext),
    .req_ext   (use_ext),
    .clk_out   (clk_out),
    .en_int    (en_i),
    .en_ext    (en_e)
  );

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      done_sync <= '0;
      on_sync   <= '0;
    end else begin
      done_sync <= {done_sync[0], done_e};
      on_sync   <= {on_sync[0], en_e};
    end
  end

  assign ost_done = done_sync[1];
  assign on_ext   = on_sync[1];
  assign clk_fail = failed;

  // R5: a settled sleep state keeps the internal enable closed
  a_r5_sleep_gates_int: assert property (@(posedge clk_int) disable iff (!rst_n)
    (sleeping && $past(sleeping) && $past(sleeping, 2)) |-> !en_i);
endmodule

// File: tb/tb_clk_src_switch.sv
`timescale 1ns/1ps
module tb_clk_src_switch;
  localparam int OST = 1024;
  localparam int RDY = 4;
  localparam int STB = 16;

  logic       clk_int, clk_ext, rst_n, int_en, sleep_req, sel_ext_req, fscm_en;
  logic [7:0] fail_limit;
  logic       clk_out, on_ext, ost_done, clk_fail, int_ready, int_stable;
  logic       ext_run, no_fail_phase;

  int total = 0;
  int bad   = 0;
  int ext_edges = 0;
  int out_edges = 0;
  int short_ph  = 0;
  int m_cnt = 0;
  realtime t_rise = 0.0, t_fall = 0.0;

  clk_src_switch dut (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .int_en(int_en),
    .sleep_req(sleep_req), .sel_ext_req(sel_ext_req), .fscm_en(fscm_en),
    .fail_limit(fail_limit), .clk_out(clk_out), .on_ext(on_ext),
    .ost_done(ost_done), .clk_fail(clk_fail), .int_ready(int_ready),
    .int_stable(int_stable)
  );

  initial clk_int = 1'b0;
  always #2 clk_int = ~clk_int;

  initial begin
    clk_ext = 1'b0;
    #1;
    forever begin
      #6;
      if (ext_run) clk_ext = ~clk_ext;
      else         clk_ext = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk_ext) ext_edges++;

  // R3 phase monitor
  always @(posedge clk_out) begin
    out_edges++;
    if (rst_n && t_fall > 0.0 && ($realtime - t_fall) < 1.9) short_ph++;
    t_rise = $realtime;
  end
  always @(negedge clk_out) begin
    if (rst_n && t_rise > 0.0 && ($realtime - t_rise) < 1.9) short_ph++;
    t_fall = $realtime;
  end

  // R7 reference model, compared on every clock
  always @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)          m_cnt = 0;
    else if (!int_en)    m_cnt = 0;
    else if (m_cnt < STB) m_cnt++;
  end
  always @(negedge clk_int) begin
    if (rst_n) begin
      chk(int_ready == (m_cnt >= RDY), "R7", "int_ready", int_ready, m_cnt >= RDY);
      chk(int_stable == (m_cnt >= STB), "R7", "int_stable", int_stable, m_cnt >= STB);
      if (no_fail_phase) chk(clk_fail == 1'b0, "R10", "clk_fail with monitor off", clk_fail, 0);
    end
  end

  task automatic wait_ost(output int n, output bit ok);
    int e0 = ext_edges;
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk_int);
      if (ost_done) begin ok = 1'b1; break; end
    end
    n = ext_edges - e0;
  endtask

  task automatic wait_on(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_int);
      if (on_ext) begin ok = 1'b1; break; end
    end
  endtask

  task automatic period_ps(output longint p);
    realtime t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = longint'(($realtime - t0) * 1000.0);
  endtask

  task automatic cycles_to_fail(output int c);
    c = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_int);
      c++;
      if (clk_fail) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n; bit ok; longint p; int c;
    rst_n = 1'b0; int_en = 1'b1; sleep_req = 1'b0; sel_ext_req = 1'b1;
    fscm_en = 1'b1; fail_limit = 8'd8; ext_run = 1'b1; no_fail_phase = 1'b0;
    repeat (5) @(negedge clk_int);
    chk(ost_done == 0, "R1", "ost_done in reset", ost_done, 0);
    chk(on_ext == 0, "R2", "on_ext in reset", on_ext, 0);
    chk(clk_fail == 0, "R8", "clk_fail in reset", clk_fail, 0);
    chk(int_ready == 0, "R7", "int_ready in reset", int_ready, 0);
    rst_n = 1'b1;

    // two-speed start-up after reset
    wait_ost(n, ok);
    chk(ok && n >= OST && n <= OST + 10, "R1", "ext edges to done after reset", n, OST);
    chk(on_ext == 0, "R2", "on_ext when done first seen", on_ext, 0);
    wait_on(ok);
    chk(ok, "R2", "on_ext after done", on_ext, 1);
    period_ps(p);
    chk(p == 12000, "R2", "clk_out period on ext (ps)", p, 12000);

    // internal oscillator disable
    @(negedge clk_int); int_en = 1'b0;
    @(negedge clk_int);
    chk(!int_ready && !int_stable, "R7", "flags after disable", {int_ready, int_stable}, 0);
    int_en = 1'b1;

    // sleep and wake
    sleep_req = 1'b1;
    repeat (10) @(negedge clk_int);
    n = out_edges;
    repeat (30) @(negedge clk_int);
    chk(out_edges == n, "R5", "clk_out edges in sleep", out_edges - n, 0);
    chk(on_ext == 0, "R5", "on_ext in sleep", on_ext, 0);
    chk(ost_done == 0, "R4", "ost_done cleared in sleep", ost_done, 0);
    sleep_req = 1'b0;
    wait_ost(n, ok);
    chk(ok && n >= OST && n <= OST + 10, "R4", "ext edges to done after wake", n, OST);
    wait_on(ok);
    chk(ok, "R4", "on_ext after wake", on_ext, 1);

    // back to internal, then re-request external
    sel_ext_req = 1'b0;
    repeat (20) @(negedge clk_int);
    chk(on_ext == 0, "R6", "on_ext after deselect", on_ext, 0);
    chk(ost_done == 0, "R4", "ost_done cleared on internal", ost_done, 0);
    period_ps(p);
    chk(p == 4000, "R6", "clk_out period on int (ps)", p, 4000);
    @(negedge clk_int); sel_ext_req = 1'b1;
    wait_ost(n, ok);
    chk(ok && n >= OST && n <= OST + 10, "R4", "ext edges to done after re-request", n, OST);
    wait_on(ok);
    chk(ok, "R4", "on_ext after re-request", on_ext, 1);

    // external clock dies while in use
    @(negedge clk_int); ext_run = 1'b0;
    cycles_to_fail(c);
    chk(clk_fail && c >= 8 && c <= 18, "R8", "cycles to clk_fail", c, 8);
    repeat (10) @(negedge clk_int);
    chk(on_ext == 0, "R8", "on_ext after failure", on_ext, 0);
    period_ps(p);
    chk(p == 4000, "R8", "clk_out period after failure (ps)", p, 4000);
    repeat (20) @(negedge clk_int);
    chk(clk_fail == 1, "R8", "clk_fail held", clk_fail, 1);
    sel_ext_req = 1'b0;
    repeat (2) @(negedge clk_int);
    chk(clk_fail == 0, "R8", "clk_fail after deselect", clk_fail, 0);

    // external oscillator never starts
    fail_limit = 8'd20;
    repeat (5) @(negedge clk_int);
    sel_ext_req = 1'b1;
    cycles_to_fail(c);
    chk(clk_fail && c >= 20 && c <= 30, "R9", "cycles to clk_fail on slow start", c, 20);
    chk(on_ext == 0, "R9", "on_ext on slow start", on_ext, 0);

    // monitoring disabled
    sel_ext_req = 1'b0; fscm_en = 1'b0;
    repeat (5) @(negedge clk_int);
    no_fail_phase = 1'b1;
    sel_ext_req = 1'b1;
    repeat (100) @(negedge clk_int);
    chk(clk_fail == 0, "R10", "clk_fail with dead ext", clk_fail, 0);
    chk(on_ext == 0, "R10", "on_ext with dead ext", on_ext, 0);
    ext_run = 1'b1;
    wait_ost(n, ok);
    chk(ok && n >= OST && n <= OST + 10, "R10", "ext edges to done after late start", n, OST);
    wait_on(ok);
    chk(ok, "R10", "on_ext after late start", on_ext, 1);
    no_fail_phase = 1'b0;

    repeat (5) @(negedge clk_int);
    chk(short_ph == 0, "R3", "short clk_out phases", short_ph, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule